// File: doc/BRIEF.md
# Strand Pause Timer

This block stalls one hardware strand for a programmed number of clock cycles. Software writes a 64-bit cycle count. The timer keeps only the count divided by the granularity, which is 8 cycles by default. It then holds a stall output high while an internal counter runs down. The counter loses one unit every 8 clock cycles. A divider restarts on every write, so the first decrement comes a full 8 cycles after the load. A count that divides down to zero still gives a one-cycle stall.

A disrupting trap, from a source not tied to this clock, releases the stall early. The trap passes through a synchronizer whose depth is a parameter. A new write during a stall replaces the remaining count. A one-cycle done pulse marks the first cycle after a stall ends, whether it ran out or was cut short.

Top module: `strand_pause_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both `block` and `done` are low.
- R2: A write with value V where V/8 (integer, the three low bits dropped) is N ≥ 1 makes `block` high from the cycle after the write for exactly 8·N cycles, provided no other write or trap arrives in that time.
- R3: A write with any value below 8, zero included, makes `block` high for exactly one cycle.
- R4: A write while `block` is high reloads the count and restarts the 8-cycle divider. `block` then stays high for 8·N' cycles after the new write, and `done` does not pulse in between.
- R5: `trap_in` high at a clock edge (with the default two synchronizer stages) makes `block` low from the third edge onward, unless a write arrives at that edge.
- R6: `done` is high for exactly one cycle: the first cycle in which `block` is low after having been high. It is never high at any other time.
- R7: With no write, a trap or any other input leaves an idle timer idle: `block` and `done` stay low.
- R8: When a write and a synchronized trap take effect at the same edge, the write wins and the new stall begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Load a new pause count this cycle |
| wr_val | input | 64 | Pause length in cycles |
| trap_in | input | 1 | Disrupting trap, asynchronous, releases the stall |
| block | output | 1 | Strand stalled |
| done | output | 1 | One-cycle pulse after a stall ends |

## Verification
The checker assumes that `wr_val` is only meaningful in cycles where `wr_en` is high. It also assumes that trap effects are only seen after the synchronizer, so the trap-release property is stated on the synchronized signal and not on the raw pin. The bench drives every input half a cycle away from the sampling edge. This keeps the trap input one clean level per cycle, so the reference model can delay it by exactly the synchronizer depth. The stimulus mixes short values, zero, values with nonzero low bits, writes during a stall, and traps both while idle and during a stall. It also includes a trap timed to reach the counter in the same cycle as a write.

// File: rtl/strand_pause_pkg.sv
package strand_pause_pkg;

   localparam int unsigned DEF_DATA_W    = 64;
   localparam int unsigned DEF_GRAN_LOG2 = 3;
   localparam int unsigned DEF_SYNC      = 2;

   // Number of granules held by the counter for a raw cycle value.
   function automatic logic [DEF_DATA_W-1:0] to_granules(
      input logic [DEF_DATA_W-1:0] raw,
      input int unsigned           shift
   );
      return raw >> shift;
   endfunction

endpackage

// File: rtl/sp_trap_sync.sv
module sp_trap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic sync_out
);

   initial begin
      assert (STAGES <= 4) else $error("sp_trap_sync: STAGES above 4");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else if (STAGES == 1) chain_q <= async_in;
            else chain_q <= {chain_q[STAGES-2:0], async_in};
         end
         assign sync_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sp_prescaler.sv
module sp_prescaler #(
   parameter int unsigned GRAN_LOG2 = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);

   logic [GRAN_LOG2-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst || restart) phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
   end

   assign tick = &phase_q;

endmodule

// File: rtl/sp_granule_counter.sv
module sp_granule_counter #(
   parameter int unsigned CNT_W = 61
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             kill,
   output logic             busy
);

   logic [CNT_W-1:0] remain_q;
   logic             short_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= '0;
         short_q  <= 1'b0;
      end else if (load) begin
         remain_q <= load_val;
         short_q  <= (load_val == '0);
      end else if (kill) begin
         remain_q <= '0;
         short_q  <= 1'b0;
      end else begin
         short_q <= 1'b0;
         if (tick && (remain_q != '0)) remain_q <= remain_q - 1'b1;
      end
   end

   assign busy = (remain_q != '0) || short_q;

endmodule

// File: rtl/strand_pause_timer.sv
module strand_pause_timer
   import strand_pause_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned GRAN_LOG2 = DEF_GRAN_LOG2,
   parameter int unsigned SYNC      = DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_val,
   input  logic              trap_in,
   output logic              block,
   output logic              done
);

   localparam int unsigned CNT_W = DATA_W - GRAN_LOG2;

   initial begin
      assert (GRAN_LOG2 >= 1 && GRAN_LOG2 < DATA_W)
         else $error("strand_pause_timer: bad GRAN_LOG2");
      assert (DATA_W <= 64) else $error("strand_pause_timer: DATA_W above 64");
   end

   logic             trap_eff;
   logic             tick;
   logic             busy;
   logic             busy_prev_q;
   logic [CNT_W-1:0] granules;

   assign granules = wr_val[DATA_W-1:GRAN_LOG2];

   sp_trap_sync #(.STAGES(SYNC)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (trap_in),
      .sync_out (trap_eff)
   );

   sp_prescaler #(.GRAN_LOG2(GRAN_LOG2)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .restart (wr_en),
      .tick    (tick)
   );

   sp_granule_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (wr_en),
      .load_val (granules),
      .tick     (tick),
      .kill     (trap_eff),
      .busy     (busy)
   );

   always_ff @(posedge clk) begin
      if (rst) busy_prev_q <= 1'b0;
      else     busy_prev_q <= busy;
   end

   assign block = busy;
   assign done  = busy_prev_q && !busy;

endmodule

// File: rtl/strand_pause_chk.sv
module strand_pause_chk #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned GRAN_LOG2 = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_val,
   input logic              trap_eff,
   input logic              block,
   input logic              done
);

   logic short_wr;
   assign short_wr = wr_en && ((wr_val >> GRAN_LOG2) == '0);

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!block && !done));

   p_write_blocks_r2: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> block);

   p_short_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
      short_wr ##1 !wr_en |=> !block);

   p_trap_release_r5: assert property (@(posedge clk) disable iff (rst)
      (trap_eff && !wr_en) |=> !block);

   p_done_edge_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> (!block && $past(block)));

   p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_idle_stays_r7: assert property (@(posedge clk) disable iff (rst)
      (!block && !wr_en) |=> (!block && !done));

endmodule

bind strand_pause_timer strand_pause_chk #(
   .DATA_W    (DATA_W),
   .GRAN_LOG2 (GRAN_LOG2)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_val   (wr_val),
   .trap_eff (trap_eff),
   .block    (block),
   .done     (done)
);

// File: tb/tb_strand_pause_timer.sv
`timescale 1ns/1ps
module tb_strand_pause_timer;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [63:0] wr_val;
   logic        trap_in;
   logic        block;
   logic        done;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit finished = 0;
   string tag = "R1";

   // reference model state
   longint unsigned m_cnt;
   int  m_pre;
   bit  m_short, m_s0, m_s1, m_block, m_done;

   always #4 clk = ~clk;

   strand_pause_timer dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_val(wr_val),
      .trap_in(trap_in), .block(block), .done(done)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_pre = 0; m_short = 0; m_s0 = 0; m_s1 = 0;
      m_block = 0; m_done = 0;
   endtask

   task automatic model_edge(input bit we, input longint unsigned val, input bit tr);
      bit eff, prev;
      eff  = m_s1;
      prev = m_block;
      m_s1 = m_s0;
      m_s0 = tr;
      if (we) begin
         m_cnt = val >> 3; m_short = (m_cnt == 0); m_pre = 0;
      end else begin
         if (eff) begin
            m_cnt = 0; m_short = 0;
         end else begin
            m_short = 0;
            if (m_pre == 7 && m_cnt != 0) m_cnt--;
         end
         m_pre = (m_pre + 1) % 8;
      end
      m_block = (m_cnt != 0) || m_short;
      m_done  = prev && !m_block;
   endtask

   // One cycle: drive at the falling edge, compare just after the rising edge.
   task automatic step(input bit we, input longint unsigned val, input bit tr);
      @(negedge clk);
      wr_en = we; wr_val = val; trap_in = tr;
      @(posedge clk);
      model_edge(we, val, tr);
      #2;
      check(tag, "block", block, m_block);
      check(tag, "done", done, m_done);
   endtask

   // Write then idle; count block-high cycles and done pulses.
   task automatic timed_write(input longint unsigned val, input int exp_len,
                              input string req);
      int len, pulses;
      len = 0; pulses = 0;
      tag = req;
      step(1, val, 0);
      for (int i = 0; i < 2000 && (block || done); i++) begin
         if (block) len++;
         if (done) pulses++;
         step(0, 0, 0);
      end
      if (done) pulses++;
      check(req, "stall length", len, exp_len);
      check("R6", "done pulses", pulses, 1);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int len;
      rst = 1; wr_en = 0; wr_val = '0; trap_in = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #2;
      tag = "R1";
      check("R1", "block in reset", block, 0);
      check("R1", "done in reset", done, 0);
      @(negedge clk); rst = 0;
      step(0, 0, 0);
      step(0, 0, 0);

      // R2: plain loads, low bits discarded
      timed_write(64, 64, "R2");
      timed_write(71, 64, "R2");
      timed_write(8, 8, "R2");
      timed_write(200, 200, "R2");

      // R3: short values including zero
      timed_write(5, 1, "R3");
      timed_write(0, 1, "R3");
      timed_write(7, 1, "R3");

      // R4: reload mid-stall
      tag = "R4";
      step(1, 80, 0);
      repeat (20) step(0, 0, 0);
      step(1, 24, 0);
      len = 0;
      for (int i = 0; i < 500 && block; i++) begin
         len++;
         check("R4", "no done during reload", done, 0);
         step(0, 0, 0);
      end
      check("R4", "reloaded length", len, 24);
      repeat (3) step(0, 0, 0);

      // R5: trap cuts a long stall
      tag = "R5";
      step(1, 800, 0);
      repeat (10) step(0, 0, 0);
      step(0, 0, 1);
      step(0, 0, 0);
      check("R5", "block before sync delay", block, 1);
      step(0, 0, 0);
      check("R5", "block after trap", block, 0);
      check("R6", "done after trap", done, 1);
      repeat (3) step(0, 0, 0);

      // R7: trap while idle does nothing
      tag = "R7";
      step(0, 0, 1);
      step(0, 0, 1);
      repeat (4) step(0, 0, 0);
      check("R7", "idle block", block, 0);
      check("R7", "idle done", done, 0);

      // R8: write arrives with a synchronized trap
      tag = "R8";
      step(0, 0, 1);
      step(0, 0, 0);
      step(1, 16, 0);
      check("R8", "write wins over trap", block, 1);
      len = 1;
      for (int i = 0; i < 200 && block; i++) begin
         step(0, 0, 0);
         if (block) len++;
      end
      check("R8", "length after write", len, 16);
      repeat (3) step(0, 0, 0);

      // R1: reset in the middle of a stall
      tag = "R1";
      step(1, 400, 0);
      repeat (5) step(0, 0, 0);
      @(negedge clk); rst = 1; wr_en = 0;
      @(posedge clk); model_reset(); #2;
      check("R1", "block after mid reset", block, 0);
      check("R1", "done after mid reset", done, 0);
      @(negedge clk); rst = 0;
      repeat (3) step(0, 0, 0);

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule